// File: doc/BRIEF.md
# SMBus Bus State and Timeout Monitor

This block watches the clock and data wires of a two-wire SMBus segment and keeps track of whether a transfer is under way. Both wires are first brought into the system clock domain through a short flip-flop chain. From the synchronized levels the block finds the start and stop conditions and holds a busy flag between them. It runs two timeouts. The bus-free timeout counts bit-rate ticks while both wires sit high and declares the bus idle once that has lasted long enough. The clock-low timeout counts system cycles while the clock wire is held low and raises an interrupt so that firmware can reset the link.

The bit-rate tick is one of four external single-cycle overflow strobes, chosen by a 2-bit select. A separate gate merges slave-event and master-event requests into one interrupt line, and an inhibit input can mute the slave events. A global enable freezes all monitoring. Every configuration input is expected to be zero out of reset, which leaves the block idle.

Top module: `smb_bus_monitor`

## Requirements
- R1: During reset and right after it, busy_o, start_o, stop_o, free_o, low_to_o and evt_irq_o are all 0.
- R2: While en_i is 0, no condition, timeout or interrupt is reported and busy_o stays 0, whatever the wires and event inputs do.
- R3: A falling edge of data while the synchronized clock is high is a START. start_o is high for exactly one cycle, 3 cycles after the raw data change, and busy_o becomes 1 in the cycle after that.
- R4: A rising edge of data while the synchronized clock is high is a STOP. stop_o is high for exactly one cycle, 3 cycles after the raw data change, and busy_o returns to 0 in the cycle after that.
- R5: Data changes while the clock is low give neither START nor STOP.
- R6: With free_to_en_i set, free_o pulses for one cycle in the cycle after the 11th selected tick seen while both synchronized wires are high (more than FREE_TICKS = 10). busy_o clears one cycle after that pulse.
- R7: The bus-free tick count restarts whenever either wire goes low. After firing it saturates, so later ticks on an idle bus produce no further pulse.
- R8: tick_sel_i value k selects bit k of tick_src_i as the bit-rate tick: 0 is timer-0 overflow, 1 is timer-1 overflow, 2 is timer-2 high-byte overflow and 3 is timer-2 low-byte overflow. Ticks on the other three bits are not counted.
- R9: With low_to_en_i set, the clock-low counter is held at low_reload_i while the synchronized clock is high and counts down once per cycle while it is low. low_to_o pulses exactly low_reload_i + 3 cycles after the raw clock falls, and does not pulse if the clock returns high sooner.
- R10: low_to_o fires once per low period and rearms only after the clock has been high again. With low_to_en_i at 0 it never fires.
- R11: evt_irq_o is 1 in the cycle after an edge at which en_i is 1 and either mst_evt_i is 1, or slv_evt_i is 1 while slv_inhibit_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global monitor enable |
| free_to_en_i | input | 1 | Enables the bus-free timeout |
| low_to_en_i | input | 1 | Enables the clock-low timeout |
| tick_sel_i | input | 2 | Selects which bit of tick_src_i is the bit-rate tick |
| tick_src_i | input | 4 | Four single-cycle overflow strobes |
| low_reload_i | input | LOW_CNT_W | Reload value of the clock-low counter, in system cycles |
| slv_inhibit_i | input | 1 | Mutes slave-event interrupts |
| slv_evt_i | input | 1 | Slave-event interrupt request |
| mst_evt_i | input | 1 | Master-event interrupt request |
| scl_i | input | 1 | Raw clock wire level |
| sda_i | input | 1 | Raw data wire level |
| busy_o | output | 1 | A transfer is in progress |
| start_o | output | 1 | One-cycle START pulse |
| stop_o | output | 1 | One-cycle STOP pulse |
| free_o | output | 1 | One-cycle bus-free timeout pulse |
| low_to_o | output | 1 | One-cycle clock-low timeout interrupt |
| evt_irq_o | output | 1 | Gated event interrupt |

## Verification
Each result has a fixed delay from its stimulus. A START or STOP pulse appears 3 cycles after the raw data change, and busy_o follows one cycle later. free_o appears one cycle after the counting tick, with busy_o clearing one cycle after that. low_to_o appears low_reload_i + 3 cycles after the raw clock falls. evt_irq_o appears one cycle after its request. When the bench applies a stimulus, it records the exact cycle number at which each result is due, along with the value expected in the cycles just before and just after. At every falling clock edge, any expectation whose cycle has come is compared with the outputs. The one-cycle width of each pulse and the absence of early or repeated pulses are therefore checked at exact cycles and not over loose windows.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;
    localparam int TICK_SEL_W = 2;
    localparam int NUM_TICK   = 1 << TICK_SEL_W;

    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic start;
        logic stop;
    } cond_st_t;

    typedef struct packed {
        logic busy;
        logic irq;
    } top_st_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    // idle bus reads high, so reset to 1s
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
    import smb_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o
);
    cond_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;
        // conditions need clock high both before and now
        st_d.start = en && st_q.scl_p && scl_s && st_q.sda_p && !sda_s;
        st_d.stop  = en && st_q.scl_p && scl_s && !st_q.sda_p && sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_p: 1'b1, sda_p: 1'b1, start: 1'b0, stop: 1'b0};
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign stop_o  = st_q.stop;
endmodule

// File: rtl/smb_free_timer.sv
module smb_free_timer #(
    parameter int FREE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic scl_s,
    input  logic sda_s,
    output logic free_o
);
    localparam int CW = $clog2(FREE_TICKS + 1) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          pulse;
    } free_st_t;

    free_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en || !(scl_s && sda_s)) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (tick && !st_q.done) begin
            if (st_q.cnt == CW'(FREE_TICKS)) begin
                st_d.pulse = 1'b1;
                st_d.done  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign free_o = st_q.pulse;
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    input  logic             scl_s,
    output logic             timeout_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             pulse;
    } low_st_t;

    low_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en || scl_s) begin
            st_d.cnt   = reload;
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout_o = st_q.pulse;
endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor
    import smb_mon_pkg::*;
#(
    parameter int LOW_CNT_W   = 20,
    parameter int FREE_TICKS  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  free_to_en_i,
    input  logic                  low_to_en_i,
    input  logic [TICK_SEL_W-1:0] tick_sel_i,
    input  logic [NUM_TICK-1:0]   tick_src_i,
    input  logic [LOW_CNT_W-1:0]  low_reload_i,
    input  logic                  slv_inhibit_i,
    input  logic                  slv_evt_i,
    input  logic                  mst_evt_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  busy_o,
    output logic                  start_o,
    output logic                  stop_o,
    output logic                  free_o,
    output logic                  low_to_o,
    output logic                  evt_irq_o
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       tick_sel;
    logic       start_w, stop_w, free_w;
    top_st_t    st_d, st_q;

    smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    assign tick_sel = tick_src_i[tick_sel_i];

    smb_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_i),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start_w),
        .stop_o  (stop_w)
    );

    smb_free_timer #(.FREE_TICKS(FREE_TICKS)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_i && free_to_en_i),
        .tick   (tick_sel),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .free_o (free_w)
    );

    smb_low_timer #(.CNT_W(LOW_CNT_W)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_i && low_to_en_i),
        .reload    (low_reload_i),
        .scl_s     (scl_s),
        .timeout_o (low_to_o)
    );

    always_comb begin
        st_d = st_q;
        if (!en_i)                 st_d.busy = 1'b0;
        else if (start_w)          st_d.busy = 1'b1;
        else if (stop_w || free_w) st_d.busy = 1'b0;
        st_d.irq = en_i && (mst_evt_i || (slv_evt_i && !slv_inhibit_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign evt_irq_o = st_q.irq;
    assign start_o   = start_w;
    assign stop_o    = stop_w;
    assign free_o    = free_w;
endmodule

// File: rtl/smb_bus_monitor_chk.sv
module smb_bus_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic slv_inhibit_i,
    input logic mst_evt_i,
    input logic busy_o,
    input logic start_o,
    input logic stop_o,
    input logic free_o,
    input logic low_to_o,
    input logic evt_irq_o
);
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !(start_o || stop_o || free_o || busy_o || evt_irq_o));
    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && en_i) |=> busy_o);
    a_r4_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);
    a_r4_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !busy_o);
    a_r4_no_start_and_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
    a_r6_free_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (free_o && !start_o) |=> !busy_o);
    a_r7_free_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |=> !free_o);
    a_r10_low_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        low_to_o |=> !low_to_o);
    a_r11_inhibit_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(slv_inhibit_i) && !$past(mst_evt_i)) |-> !evt_irq_o);
endmodule

bind smb_bus_monitor smb_bus_monitor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .slv_inhibit_i (slv_inhibit_i),
    .mst_evt_i     (mst_evt_i),
    .busy_o        (busy_o),
    .start_o       (start_o),
    .stop_o        (stop_o),
    .free_o        (free_o),
    .low_to_o      (low_to_o),
    .evt_irq_o     (evt_irq_o)
);

// File: tb/smb_bus_monitor_tb.sv
module smb_bus_monitor_tb;
    localparam int S_BUSY = 0, S_START = 1, S_STOP = 2, S_FREE = 3, S_LOW = 4, S_IRQ = 5;

    typedef struct {
        int    cyc;
        int    sig;
        logic  exp;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, free_to_en_i = 1'b0, low_to_en_i = 1'b0;
    logic [1:0]  tick_sel_i = 2'd0;
    logic [3:0]  tick_src_i = 4'd0;
    logic [19:0] low_reload_i = 20'd0;
    logic        slv_inhibit_i = 1'b0, slv_evt_i = 1'b0, mst_evt_i = 1'b0;
    logic        scl_i = 1'b1, sda_i = 1'b1;
    logic        busy_o, start_o, stop_o, free_o, low_to_o, evt_irq_o;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    smb_bus_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .free_to_en_i(free_to_en_i),
        .low_to_en_i(low_to_en_i), .tick_sel_i(tick_sel_i), .tick_src_i(tick_src_i),
        .low_reload_i(low_reload_i), .slv_inhibit_i(slv_inhibit_i),
        .slv_evt_i(slv_evt_i), .mst_evt_i(mst_evt_i), .scl_i(scl_i), .sda_i(sda_i),
        .busy_o(busy_o), .start_o(start_o), .stop_o(stop_o), .free_o(free_o),
        .low_to_o(low_to_o), .evt_irq_o(evt_irq_o)
    );

    function automatic logic get_sig(int s);
        case (s)
            S_BUSY:  return busy_o;
            S_START: return start_o;
            S_STOP:  return stop_o;
            S_FREE:  return free_o;
            S_LOW:   return low_to_o;
            default: return evt_irq_o;
        endcase
    endfunction

    task automatic check_now(int s, logic e, string tag);
        logic a = get_sig(s);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s sig=%0d cyc=%0d actual=%b expected=%b", tag, s, cyc, a, e);
        end
    endtask

    // driver side: queue an expectation dly cycles from now
    task automatic expect_at(int dly, int s, logic e, string tag);
        item_t it;
        it.cyc = cyc + dly; it.sig = s; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor side
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                check_now(sb[i].sig, sb[i].exp, sb[i].tag);
                sb.delete(i);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick(int idx);
        tick_src_i[idx] = 1'b1;
        @(negedge clk);
        tick_src_i[idx] = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        // R1: reset state
        for (int s = 0; s < 6; s++) check_now(s, 1'b0, "R1");
        rst_n = 1'b1;
        wait_cyc(2);
        for (int s = 0; s < 6; s++) check_now(s, 1'b0, "R1");

        // R2: disabled block ignores everything
        low_to_en_i = 1'b1; free_to_en_i = 1'b1; low_reload_i = 20'd20;
        sda_i = 1'b0;
        expect_at(3, S_START, 1'b0, "R2"); expect_at(4, S_BUSY, 1'b0, "R2");
        wait_cyc(6);
        sda_i = 1'b1;
        expect_at(3, S_STOP, 1'b0, "R2");
        wait_cyc(6);
        scl_i = 1'b0;
        expect_at(23, S_LOW, 1'b0, "R2");
        slv_evt_i = 1'b1; expect_at(1, S_IRQ, 1'b0, "R2");
        wait_cyc(1); slv_evt_i = 1'b0;
        wait_cyc(29);
        scl_i = 1'b1;
        wait_cyc(5);

        // R3: START
        en_i = 1'b1; tick_sel_i = 2'd1;
        wait_cyc(5);
        sda_i = 1'b0;
        expect_at(2, S_START, 1'b0, "R3"); expect_at(3, S_START, 1'b1, "R3");
        expect_at(4, S_START, 1'b0, "R3"); expect_at(3, S_BUSY, 1'b0, "R3");
        expect_at(4, S_BUSY, 1'b1, "R3");
        wait_cyc(6);

        // R5 and R9: data moves while clock low, short low period
        scl_i = 1'b0;
        expect_at(23, S_LOW, 1'b0, "R9");
        wait_cyc(2);
        sda_i = 1'b1; expect_at(3, S_STOP, 1'b0, "R5");
        wait_cyc(2);
        sda_i = 1'b0; expect_at(3, S_START, 1'b0, "R5"); expect_at(4, S_BUSY, 1'b1, "R5");
        wait_cyc(6);
        scl_i = 1'b1;
        wait_cyc(6);

        // R4: STOP
        sda_i = 1'b1;
        expect_at(3, S_STOP, 1'b1, "R4"); expect_at(4, S_STOP, 1'b0, "R4");
        expect_at(3, S_BUSY, 1'b1, "R4"); expect_at(4, S_BUSY, 1'b0, "R4");
        wait_cyc(20);

        // R9/R10: clock-low timeout fires once
        scl_i = 1'b0;
        expect_at(22, S_LOW, 1'b0, "R9"); expect_at(23, S_LOW, 1'b1, "R9");
        expect_at(24, S_LOW, 1'b0, "R10"); expect_at(60, S_LOW, 1'b0, "R10");
        wait_cyc(65);
        scl_i = 1'b1;
        wait_cyc(5);
        // R10: rearmed after clock high
        scl_i = 1'b0;
        expect_at(23, S_LOW, 1'b1, "R10");
        wait_cyc(30);
        scl_i = 1'b1;
        wait_cyc(5);
        // R10: disabled timeout
        low_to_en_i = 1'b0;
        wait_cyc(2);
        scl_i = 1'b0;
        expect_at(23, S_LOW, 1'b0, "R10"); expect_at(40, S_LOW, 1'b0, "R10");
        wait_cyc(45);
        scl_i = 1'b1; low_to_en_i = 1'b1;
        wait_cyc(5);

        // R6/R8: bus-free timeout with busy set and both lines high
        sda_i = 1'b0; wait_cyc(6);
        scl_i = 1'b0; wait_cyc(3);
        sda_i = 1'b1; wait_cyc(3);
        scl_i = 1'b1; wait_cyc(5);
        expect_at(1, S_BUSY, 1'b1, "R6");
        wait_cyc(2);
        for (int i = 0; i < 10; i++) begin
            expect_at(1, S_FREE, 1'b0, "R6"); pulse_tick(1);
            expect_at(1, S_FREE, 1'b0, "R8"); pulse_tick(0);
            expect_at(1, S_FREE, 1'b0, "R8"); pulse_tick(2);
            expect_at(1, S_FREE, 1'b0, "R8"); pulse_tick(3);
        end
        expect_at(1, S_FREE, 1'b1, "R6"); expect_at(2, S_FREE, 1'b0, "R6");
        expect_at(1, S_BUSY, 1'b1, "R6"); expect_at(2, S_BUSY, 1'b0, "R6");
        pulse_tick(1);
        wait_cyc(2);
        // R7: saturation
        for (int i = 0; i < 3; i++) begin
            expect_at(1, S_FREE, 1'b0, "R7"); pulse_tick(1); wait_cyc(1);
        end
        // R7: restart after clock low
        scl_i = 1'b0; wait_cyc(3);
        scl_i = 1'b1; wait_cyc(4);
        for (int i = 0; i < 10; i++) begin
            expect_at(1, S_FREE, 1'b0, "R7"); pulse_tick(1); wait_cyc(1);
        end
        expect_at(1, S_FREE, 1'b1, "R7");
        pulse_tick(1);
        wait_cyc(2);
        // R8: another source selected
        tick_sel_i = 2'd2;
        sda_i = 1'b1; scl_i = 1'b0; wait_cyc(3);
        scl_i = 1'b1; wait_cyc(4);
        for (int i = 0; i < 10; i++) begin
            expect_at(1, S_FREE, 1'b0, "R8"); pulse_tick(2);
            expect_at(1, S_FREE, 1'b0, "R8"); pulse_tick(1);
        end
        expect_at(1, S_FREE, 1'b1, "R8");
        pulse_tick(2);
        wait_cyc(3);

        // R11: interrupt gating
        slv_evt_i = 1'b1; expect_at(1, S_IRQ, 1'b1, "R11");
        wait_cyc(1);
        slv_evt_i = 1'b0; expect_at(1, S_IRQ, 1'b0, "R11");
        wait_cyc(1);
        slv_inhibit_i = 1'b1; slv_evt_i = 1'b1; expect_at(1, S_IRQ, 1'b0, "R11");
        wait_cyc(1);
        slv_evt_i = 1'b0; mst_evt_i = 1'b1; expect_at(1, S_IRQ, 1'b1, "R11");
        wait_cyc(1);
        mst_evt_i = 1'b0; expect_at(1, S_IRQ, 1'b0, "R11");
        wait_cyc(4);

        while (sb.size() != 0) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog req=all actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule